// File: doc/BRIEF.md
# Frame-Sync SAR Converter Serial Reader

This block drives a successive-approximation converter that has a dedicated convert pin and an active-low frame-sync select. On a start request it raises the convert output. It holds convert high for a programmable number of system clocks that covers the converter's worst-case conversion time. The converter has no completion flag to poll, so only this timer decides when the result is ready.

Once the timer expires, convert drops and frame-sync stays high for one serial half-period. Frame-sync then falls to open the data cycle, and sixteen serial clock pulses follow. The converter presents a new bit after each rising serial clock edge. The reader samples the data line on the matching falling edge, so the first bit captured is the one presented after the first rising edge. Bits are assembled most-significant first. The finished word appears on a parallel output together with a one-cycle valid strobe, in the same cycle that frame-sync returns high. A guard interval of one full serial period with frame-sync high then completes the transaction before a new request can be accepted.

Both timing settings are taken from input pins when a request is accepted and are held for the whole transaction.

Top module: `sar_fsync_reader`

## Requirements
- R1: After a synchronous active-low reset: convert low, frame-sync high, serial clock low, valid low, busy low, data word zero.
- R2: A start request seen while idle raises convert and busy one cycle later. Convert then stays high for exactly C system clocks, where C is the conversion-count setting and a setting of 0 counts as 1.
- R3: Convert is never high while frame-sync is low. After convert falls, frame-sync stays high for H system clocks before it falls, where H is the half-period setting and a setting of 0 counts as 1.
- R4: The serial clock is low whenever frame-sync is high. It stays low for H clocks after frame-sync falls. It then gives exactly 16 pulses, each with a high phase and a low phase of H clocks.
- R5: The data line is sampled at each falling serial clock edge. The first sample is placed in bit 15 and the last in bit 0. The value on the line before the first rising edge is never used.
- R6: H clocks after the 16th falling edge, frame-sync rises. In that same cycle valid is high for exactly one cycle and the data output holds the assembled word.
- R7: After the word is delivered, frame-sync stays high and busy stays high for 2·H further cycles. A whole transaction keeps busy high for C + 36·H cycles.
- R8: A start request made while busy does not begin a new conversion. Once the running transaction ends, busy and convert stay low.
- R9: Changing the conversion-count or half-period settings during a transaction leaves that transaction's timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one conversion and readout; honoured only while idle |
| cfg_conv_cycles_i | input | CONV_W (12) | Convert-high length in system clocks (0 treated as 1) |
| cfg_half_cycles_i | input | HALF_W (6) | Serial clock phase length in system clocks (0 treated as 1) |
| sdo_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Convert output; rising edge starts a conversion |
| fs_n_o | output | 1 | Active-low frame-sync to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| data_o | output | DATA_W (16) | Last assembled word |
| valid_o | output | 1 | One-cycle strobe marking a new word on data_o |
| busy_o | output | 1 | High from request acceptance until the guard interval ends |

## Verification
The hardest cases to reach from the ports are a start request, or a change of the timing settings, that lands in one particular phase of a running transaction. The bench reaches them by counting cycles from the accepted request and raising the stray request or changing the settings at a chosen count, deep inside the shift phase. It then checks that the phase lengths, the data word and the idle state afterwards are unchanged. A converter model in the bench puts a deliberately wrong bit on the line before the first rising serial edge, so a reader that samples too early shows up as a wrong top bit.

// File: rtl/sar_rd_pkg.sv
// Shared types for the frame-sync SAR reader.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package sar_rd_pkg;

    // Transaction phases of the reader
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CONV  = 3'd1,
        ST_SETUP = 3'd2,
        ST_LEAD  = 3'd3,
        ST_HIGH  = 3'd4,
        ST_LOW   = 3'd5,
        ST_GAP   = 3'd6
    } rd_state_t;

endpackage

// File: rtl/sar_rd_timer.sv
// Phase timer: a down counter loaded with (length - 1); zero_o marks the
// last cycle of the current phase.
// Assumes: the controller reloads it on every phase change.
module sar_rd_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    // Load on phase entry, otherwise count down and stop at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sar_rd_shift.sv
// Serial-to-parallel assembler: shifts the data line in MSB first on each
// capture strobe and copies the result to the output word on commit.
// Assumes: capture and commit never fall in the same cycle.
module sar_rd_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              bit_i,
    input  logic              commit_i,
    output logic [DATA_W-1:0] word_o
);

    logic [DATA_W-1:0] sh_q;

    // Shift register: earliest sample ends up in the top bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (cap_i) begin
            sh_q <= {sh_q[DATA_W-2:0], bit_i};
        end
    end

    // Output word register: updated only when a frame completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '0;
        end else if (commit_i) begin
            word_o <= sh_q;
        end
    end

    // R5: the word is committed only after the last capture is in place
    p_no_cap_on_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_i && commit_i));

endmodule

// File: rtl/sar_rd_ctrl.sv
// Transaction controller: sequences convert, setup, frame-sync, sixteen
// serial clock pulses and the guard gap; all pin outputs are registered.
// Assumes: the timer reloads on every phase change; settings are latched
// when a request is accepted.
module sar_rd_ctrl
    import sar_rd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CONV_W = 12,
    parameter int HALF_W = 6,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CONV_W-1:0] cfg_conv_i,
    input  logic [HALF_W-1:0] cfg_half_i,
    input  logic              tmr_zero_i,
    output logic              tmr_load_o,
    output logic [CNT_W-1:0]  tmr_val_o,
    output logic              cap_o,
    output logic              commit_o,
    output logic              cnv_o,
    output logic              fs_n_o,
    output logic              sclk_o,
    output logic              valid_o,
    output logic              busy_o
);

    localparam int BIT_W = $clog2(DATA_W + 1);

    rd_state_t         st_q, st_d;
    logic [BIT_W-1:0]  bit_q, bit_d;
    logic [HALF_W-1:0] half_q;
    logic              cnv_d, fs_n_d, sclk_d, valid_d, latch;
    logic [CONV_W-1:0] conv_in;
    logic [HALF_W-1:0] half_in;
    logic [CNT_W-1:0]  half_len, gap_len;

    // Sanitise settings: a zero length counts as one clock
    always_comb begin
        conv_in  = (cfg_conv_i == '0) ? CONV_W'(1) : cfg_conv_i;
        half_in  = (cfg_half_i == '0) ? HALF_W'(1) : cfg_half_i;
        half_len = CNT_W'(half_q - 1'b1);
        gap_len  = CNT_W'({half_q, 1'b0} - 1'b1);
    end

    // Next-state and next-output decode, one phase per state
    always_comb begin
        st_d       = st_q;
        bit_d      = bit_q;
        cnv_d      = cnv_o;
        fs_n_d     = fs_n_o;
        sclk_d     = sclk_o;
        valid_d    = 1'b0;
        latch      = 1'b0;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        cap_o      = 1'b0;
        commit_o   = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_d       = ST_CONV;
                    cnv_d      = 1'b1;
                    latch      = 1'b1;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = CNT_W'(conv_in - 1'b1);
                end
            end
            ST_CONV: begin
                if (tmr_zero_i) begin
                    st_d       = ST_SETUP;
                    cnv_d      = 1'b0;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = half_len;
                end
            end
            ST_SETUP: begin
                if (tmr_zero_i) begin
                    st_d       = ST_LEAD;
                    fs_n_d     = 1'b0;
                    bit_d      = '0;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = half_len;
                end
            end
            ST_LEAD: begin
                if (tmr_zero_i) begin
                    st_d       = ST_HIGH;
                    sclk_d     = 1'b1;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = half_len;
                end
            end
            ST_HIGH: begin
                if (tmr_zero_i) begin
                    st_d       = ST_LOW;
                    sclk_d     = 1'b0;
                    cap_o      = 1'b1;
                    bit_d      = bit_q + 1'b1;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = half_len;
                end
            end
            ST_LOW: begin
                if (tmr_zero_i) begin
                    tmr_load_o = 1'b1;
                    if (bit_q == BIT_W'(DATA_W)) begin
                        st_d      = ST_GAP;
                        fs_n_d    = 1'b1;
                        valid_d   = 1'b1;
                        commit_o  = 1'b1;
                        tmr_val_o = gap_len;
                    end else begin
                        st_d      = ST_HIGH;
                        sclk_d    = 1'b1;
                        tmr_val_o = half_len;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_zero_i) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State, bit count and pin registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            bit_q   <= '0;
            cnv_o   <= 1'b0;
            fs_n_o  <= 1'b1;
            sclk_o  <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            st_q    <= st_d;
            bit_q   <= bit_d;
            cnv_o   <= cnv_d;
            fs_n_o  <= fs_n_d;
            sclk_o  <= sclk_d;
            valid_o <= valid_d;
        end
    end

    // Half-period setting captured once per transaction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= HALF_W'(1);
        end else if (latch) begin
            half_q <= half_in;
        end
    end

    assign busy_o = (st_q != ST_IDLE);

    // R3: convert never overlaps the data cycle
    p_cnv_low_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_n_o |-> !cnv_o);

    // R4: serial clock only pulses inside a frame
    p_sclk_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !fs_n_o);

    // R4: never more than DATA_W captures per frame
    p_bit_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q <= BIT_W'(DATA_W));

    // R6: valid lasts one cycle
    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R6: valid coincides with frame-sync returning high
    p_valid_at_fs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (fs_n_o && $past(!fs_n_o)));

    // R2: convert is only high inside a transaction
    p_cnv_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_o |-> busy_o);

    // R8: once past the convert phase, no request restarts a conversion
    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && st_q != ST_CONV) |=> (st_q != ST_CONV));

endmodule

// File: rtl/sar_fsync_reader.sv
// Top level of the frame-sync SAR reader: ties controller, phase timer and
// serial assembler together.
// Assumes: sdo_i is launched by the converter from sclk_o, which is itself
// derived from clk, so it settles well within one phase of H clocks.
module sar_fsync_reader #(
    parameter int DATA_W = 16,
    parameter int CONV_W = 12,
    parameter int HALF_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CONV_W-1:0] cfg_conv_cycles_i,
    input  logic [HALF_W-1:0] cfg_half_cycles_i,
    input  logic              sdo_i,
    output logic              cnv_o,
    output logic              fs_n_o,
    output logic              sclk_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              busy_o
);

    localparam int CNT_W = (CONV_W > HALF_W + 1) ? CONV_W : HALF_W + 1;

    logic             tmr_load, tmr_zero, cap, commit;
    logic [CNT_W-1:0] tmr_val;

    sar_rd_ctrl #(
        .DATA_W (DATA_W),
        .CONV_W (CONV_W),
        .HALF_W (HALF_W),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cfg_conv_i (cfg_conv_cycles_i),
        .cfg_half_i (cfg_half_cycles_i),
        .tmr_zero_i (tmr_zero),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .cap_o      (cap),
        .commit_o   (commit),
        .cnv_o      (cnv_o),
        .fs_n_o     (fs_n_o),
        .sclk_o     (sclk_o),
        .valid_o    (valid_o),
        .busy_o     (busy_o)
    );

    sar_rd_timer #(
        .W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    sar_rd_shift #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_i    (cap),
        .bit_i    (sdo_i),
        .commit_i (commit),
        .word_o   (data_o)
    );

endmodule

// File: tb/sar_fsync_reader_tb.sv
module sar_fsync_reader_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {word, conversion count, half-period count}
    localparam logic [33:0] VECS [NVEC] = '{
        {16'h7FFF, 12'd20, 6'd1},
        {16'h8000, 12'd5,  6'd2},
        {16'hA5C3, 12'd1,  6'd3},
        {16'h0001, 12'd0,  6'd0},
        {16'hFFFF, 12'd33, 6'd1},
        {16'h0000, 12'd3,  6'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] cfg_conv = 12'd1;
    logic [5:0]  cfg_half = 6'd1;
    logic        sdo = 1'b0;
    logic        cnv, fs_n, sclk, valid, busy;
    logic [15:0] data;

    int n_checks = 0;
    int n_fail = 0;
    logic [15:0] pat = 16'h0;
    int bit_idx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_fsync_reader u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .start_i           (start),
        .cfg_conv_cycles_i (cfg_conv),
        .cfg_half_cycles_i (cfg_half),
        .sdo_i             (sdo),
        .cnv_o             (cnv),
        .fs_n_o            (fs_n),
        .sclk_o            (sclk),
        .data_o            (data),
        .valid_o           (valid),
        .busy_o            (busy)
    );

    // Converter model: junk before the first rise, then one bit per rise
    always @(negedge fs_n) begin
        bit_idx = 0;
        sdo = ~pat[15];
    end
    always @(posedge sclk) begin
        if (!fs_n && bit_idx < 16) begin
            sdo = pat[15 - bit_idx];
            bit_idx++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=1 expected=0");
        finish_run();
    end

    // One transaction with measurement; poke 1 = stray start, 2 = setting change
    task automatic run_txn(input logic [15:0] w, input int c, input int h,
                           input int poke_at, input int poke);
        int ce, he, n, cnv_hi, setup, lead, rises, run, lvl, phase_err;
        int viol, vcnt, gap, busy_cyc;
        bit seen_cnv, seen_fs, in_frame, vfs_ok;
        logic [15:0] vdata;
        ce = (c == 0) ? 1 : c;
        he = (h == 0) ? 1 : h;
        pat = w;
        cfg_conv = 12'(c);
        cfg_half = 6'(h);
        cnv_hi = 0; setup = 0; lead = -1; rises = 0; run = 0; lvl = 0;
        phase_err = 0; viol = 0; vcnt = 0; gap = 0; busy_cyc = 0; n = 0;
        seen_cnv = 0; seen_fs = 0; in_frame = 0; vfs_ok = 0; vdata = '0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (busy && n < 5000) begin
            busy_cyc++;
            if (cnv) begin cnv_hi++; seen_cnv = 1; end
            if (seen_cnv && !cnv && fs_n && !seen_fs) setup++;
            if (sclk && fs_n) viol++;
            if (!fs_n) begin
                seen_fs = 1;
                if (!in_frame) begin in_frame = 1; lvl = 0; run = 0; end
                if (int'(sclk) == lvl) run++;
                else begin
                    if (lvl == 0 && rises == 0) lead = run;
                    else if (run != he) phase_err++;
                    lvl = int'(sclk); run = 1;
                    if (sclk) rises++;
                end
            end else if (in_frame) begin
                in_frame = 0;
                if (run != he) phase_err++;
            end
            if (seen_fs && fs_n) gap++;
            if (valid) begin vcnt++; vdata = data; vfs_ok = fs_n; end
            if (poke != 0 && n == poke_at) begin
                if (poke == 1) start = 1'b1;
                else begin cfg_conv = 12'(ce + 7); cfg_half = 6'(he + 2); end
            end
            if (n == poke_at + 1) start = 1'b0;
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check(cnv_hi == ce, "R2", "convert high cycles", cnv_hi, ce);
        check(setup == he && viol == 0, "R3", "convert-low to frame-sync cycles", setup, he);
        check(lead == he && rises == 16 && phase_err == 0, "R4",
              "lead/pulses/phase errors", lead * 1000 + rises * 10 + phase_err,
              he * 1000 + 160);
        check(vdata == w, "R5", "assembled word", int'(vdata), int'(w));
        check(vcnt == 1 && vfs_ok, "R6", "valid count at frame-sync rise", vcnt, 1);
        check(gap == 2 * he, "R7", "guard cycles", gap, 2 * he);
        check(busy_cyc == ce + 36 * he, "R7", "busy cycles", busy_cyc, ce + 36 * he);
        check(data == w, "R6", "data held after valid", int'(data), int'(w));
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!cnv && fs_n && !sclk && !valid && !busy && data == 16'h0, "R1",
              "reset outputs", {cnv, fs_n, sclk, valid, busy}, 5'b01000);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !cnv, "R1", "idle without request", busy, 0);

        // Table of vectors: R2..R7 plus zero-as-one settings (R2, R3)
        for (int i = 0; i < NVEC; i++) begin
            run_txn(VECS[i][33:18], int'(VECS[i][17:6]), int'(VECS[i][5:0]), 0, 0);
            @(negedge clk);
        end

        // R8: stray start deep inside the shift phase is ignored
        run_txn(16'h3C5A, 4, 2, 30, 1);
        repeat (5) @(negedge clk);
        check(!busy && !cnv && fs_n, "R8", "no restart after stray start", busy, 0);

        // R8: stray start during the convert phase is ignored
        run_txn(16'h1234, 10, 1, 2, 1);
        repeat (5) @(negedge clk);
        check(!busy && !cnv, "R8", "no restart after start in convert", busy, 0);

        // R9: settings changed mid-transaction do not alter timing
        run_txn(16'hBEEF, 6, 2, 25, 2);
        @(negedge clk);
        // R9: new settings apply to the next transaction
        run_txn(16'h5A5A, 13, 4, 0, 0);

        // R1: reset in the middle of a frame returns outputs to idle
        pat = 16'hCAFE;
        cfg_conv = 12'd3; cfg_half = 6'd2;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!cnv && fs_n && !sclk && !valid && !busy && data == 16'h0, "R1",
              "mid-frame reset outputs", {cnv, fs_n, sclk, valid, busy}, 5'b01000);
        rst_n = 1'b1;
        @(negedge clk);
        run_txn(16'h8001, 2, 1, 0, 0);

        finish_run();
    end

endmodule